// File: doc/BRIEF.md
# Disk Header Record Writer

This block turns a sector-mark trigger into the serial pulse stream for the header record of one disk sector. A write command must be present when the mark arrives. The two 16-bit header words are captured on that same cycle. After an optional start delay, the block raises the write gate and the erase gate together. It then waits a guard interval and emits the record one bit cell at a time.

The record has four parts, in this order:
- 34 zero words.
- A sync word, 0x0001.
- The two header words.
- A checksum word.

A short run of zero cells closes the record. Every bit cell opens with a clock pulse. A cell that carries a one also has a data pulse at its midpoint. A word strobe marks each 16-cell word boundary, so a controller can follow the word timing.

The gates can be held past the end of the record. In that mode they stay on until the next sector mark and then for a programmed tail time. If the tail time is zero, the gates drop as soon as the last closing cell ends.

Top module: `hdr_rec_writer`

## Requirements
- R1: While reset is high, and on the first cycle after it, `wgate`, `egate`, `flux` and `word_done` are all 0.
- R2: A `sect_mark` pulse while `wr_en` is 0 starts nothing: the gates and `flux` stay 0.
- R3: When `sect_mark` and `wr_en` are both 1 at a clock edge, the gates read 1 exactly `START_DLY` cycles after that edge.
- R4: `flux` stays 0 for exactly `LEAD_CLKS` cycles after the gates rise. The first clock pulse follows on the next cycle.
- R5: Each bit cell lasts `CELL_CLKS` cycles. `flux` is 1 in cell cycle 0, and also in cycle `CELL_CLKS/2` when the bit is 1. It is 0 in every other cycle.
- R6: The cell sequence is: 34 all-zero words, then the sync word 0x0001, then `hdr_w0`, then `hdr_w1`, then the checksum. Each word is sent most significant bit first.
- R7: The checksum word equals 0x0151 XOR `hdr_w0` XOR `hdr_w1`.
- R8: Exactly four clock-only cells follow the checksum. After them, `flux` stays 0.
- R9: `word_done` is 1 for one cycle, in the first cycle after the 16th cell of each of the 38 words. It never pulses in any other cycle.
- R10: If `TAIL_CLKS` > 0, the gates stay on after the record until the next `sect_mark`, and then for `TAIL_CLKS` more cycles. If `TAIL_CLKS` is 0, the gates fall on the cycle after the last closing cell. `wgate` and `egate` always have the same value.
- R11: A `sect_mark` that arrives while a record is being emitted leaves the stream unchanged.
- R12: The header words are captured at the starting sector mark. Changing `hdr_w0` or `hdr_w1` afterwards has no effect on the record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sect_mark | input | 1 | Sector-mark pulse, one cycle wide |
| wr_en | input | 1 | Write command, sampled at the sector mark |
| hdr_w0 | input | 16 | First header word |
| hdr_w1 | input | 16 | Second header word |
| wgate | output | 1 | Write gate |
| egate | output | 1 | Erase gate |
| flux | output | 1 | Pulse stream: clock and data pulses, one cycle wide |
| word_done | output | 1 | Strobe at the end of each 16-cell word |

## Verification
The bench builds two instances of the block.

The first instance uses a 4-cycle cell, a 5-cycle start delay, a 3-cycle guard and a 7-cycle tail. This brings the delayed-start path and the hold-until-next-mark path within a few thousand cycles.

The second instance uses a 6-cycle cell, no start delay, a 2-cycle guard and no tail. This exercises the immediate-start branch and the early gate release, with a different midpoint position.

Both instances keep the full 34-word preamble. The word strobe and the decoded checksum are therefore checked against the real frame length.

// File: rtl/hrw_pkg.sv
package hrw_pkg;

    localparam int WORD_BITS    = 16;
    localparam int PRE_WORDS_DEF = 34;
    // sync, two header words, checksum
    localparam int TRAIL_WORDS  = 4;
    localparam logic [WORD_BITS-1:0] SYNC_PATTERN = 16'h0001;
    localparam logic [WORD_BITS-1:0] CKSUM_SEED   = 16'h0151;

    typedef logic [WORD_BITS-1:0] word_t;

    typedef struct packed {
        word_t first;
        word_t second;
    } hdr_words_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DELAY,
        ST_LEAD,
        ST_CELLS,
        ST_HOLD,
        ST_TAIL
    } hrw_state_e;

    function automatic word_t hdr_cksum(input hdr_words_t w);
        return CKSUM_SEED ^ w.first ^ w.second;
    endfunction

endpackage

// File: rtl/hrw_cell_timer.sv
module hrw_cell_timer #(
    parameter int CELL_CLKS = 60
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic clk_slot,
    output logic data_slot,
    output logic cell_end
);
    localparam int PH_W = (CELL_CLKS > 1) ? $clog2(CELL_CLKS) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CELL_CLKS - 1);
    localparam logic [PH_W-1:0] PH_MID  = PH_W'(CELL_CLKS / 2);

    logic [PH_W-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase <= '0;
        end else if (phase == PH_LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign clk_slot  = run && (phase == '0);
    assign data_slot = run && (phase == PH_MID);
    assign cell_end  = run && (phase == PH_LAST);

endmodule

// File: rtl/hrw_word_source.sv
module hrw_word_source
    import hrw_pkg::*;
#(
    parameter int PRE_WORDS  = PRE_WORDS_DEF,
    parameter int POST_CELLS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       adv,
    input  hdr_words_t words,
    output logic       cur_bit,
    output logic       word_end,
    output logic       last_cell
);
    localparam int NWORDS = PRE_WORDS + TRAIL_WORDS;
    localparam int WI_W   = $clog2(NWORDS + 1);
    localparam int PC_W   = $clog2(POST_CELLS + 1);
    localparam logic [WI_W-1:0] IDX_SYNC = WI_W'(PRE_WORDS);
    localparam logic [WI_W-1:0] IDX_W0   = WI_W'(PRE_WORDS + 1);
    localparam logic [WI_W-1:0] IDX_W1   = WI_W'(PRE_WORDS + 2);
    localparam logic [WI_W-1:0] IDX_CK   = WI_W'(PRE_WORDS + 3);
    localparam logic [WI_W-1:0] IDX_END  = WI_W'(NWORDS);
    localparam logic [PC_W-1:0] PC_LAST  = PC_W'(POST_CELLS - 1);

    logic [WI_W-1:0] widx;
    logic [3:0]      bidx;
    logic [PC_W-1:0] pidx;
    logic            in_words;
    word_t           cur_word;

    assign in_words = (widx < IDX_END);

    always_comb begin
        if (widx == IDX_SYNC) begin
            cur_word = SYNC_PATTERN;
        end else if (widx == IDX_W0) begin
            cur_word = words.first;
        end else if (widx == IDX_W1) begin
            cur_word = words.second;
        end else if (widx == IDX_CK) begin
            cur_word = hdr_cksum(words);
        end else begin
            cur_word = '0;
        end
    end

    // most significant bit first: bit 15 - bidx == ~bidx
    assign cur_bit   = in_words && cur_word[~bidx];
    assign word_end  = adv && in_words && (bidx == 4'hF);
    assign last_cell = !in_words && (pidx == PC_LAST);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            widx <= '0;
            bidx <= '0;
            pidx <= '0;
        end else if (adv) begin
            if (in_words) begin
                bidx <= bidx + 1'b1;
                if (bidx == 4'hF) begin
                    widx <= widx + 1'b1;
                end
            end else begin
                pidx <= pidx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/hdr_rec_writer.sv
module hdr_rec_writer
    import hrw_pkg::*;
#(
    parameter int CELL_CLKS  = 60,
    parameter int START_DLY  = 2500,
    parameter int LEAD_CLKS  = 200,
    parameter int TAIL_CLKS  = 2500,
    parameter int PRE_WORDS  = PRE_WORDS_DEF,
    parameter int POST_CELLS = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sect_mark,
    input  logic        wr_en,
    input  logic [15:0] hdr_w0,
    input  logic [15:0] hdr_w1,
    output logic        wgate,
    output logic        egate,
    output logic        flux,
    output logic        word_done
);
    localparam int MAX_AB = (START_DLY > LEAD_CLKS) ? START_DLY : LEAD_CLKS;
    localparam int MAX_C  = (MAX_AB > TAIL_CLKS) ? MAX_AB : TAIL_CLKS;
    localparam int CNT_W  = $clog2(MAX_C + 2);
    localparam logic [CNT_W-1:0] D_LAST = CNT_W'((START_DLY > 0) ? START_DLY - 1 : 0);
    localparam logic [CNT_W-1:0] L_LAST = CNT_W'((LEAD_CLKS > 0) ? LEAD_CLKS - 1 : 0);
    localparam logic [CNT_W-1:0] T_LAST = CNT_W'((TAIL_CLKS > 0) ? TAIL_CLKS - 1 : 0);

    hrw_state_e       st;
    hrw_state_e       start_st;
    hrw_state_e       done_st;
    logic [CNT_W-1:0] cnt;
    hdr_words_t       words_q;
    logic             running;
    logic             clk_slot, data_slot, cell_end;
    logic             cur_bit, word_end, last_cell;

    // parameter-selected entry and exit states
    generate
        if (START_DLY == 0) begin : g_no_delay
            assign start_st = ST_LEAD;
        end else begin : g_delay
            assign start_st = ST_DELAY;
        end
        if (TAIL_CLKS == 0) begin : g_no_tail
            assign done_st = ST_IDLE;
        end else begin : g_tail
            assign done_st = ST_HOLD;
        end
    endgenerate

    assign running = (st == ST_CELLS);

    hrw_cell_timer #(
        .CELL_CLKS(CELL_CLKS)
    ) u_cell_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (running),
        .clk_slot (clk_slot),
        .data_slot(data_slot),
        .cell_end (cell_end)
    );

    hrw_word_source #(
        .PRE_WORDS (PRE_WORDS),
        .POST_CELLS(POST_CELLS)
    ) u_word_source (
        .clk      (clk),
        .rst      (rst),
        .clear    (!running),
        .adv      (cell_end),
        .words    (words_q),
        .cur_bit  (cur_bit),
        .word_end (word_end),
        .last_cell(last_cell)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            words_q <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (sect_mark && wr_en) begin
                        st      <= start_st;
                        cnt     <= '0;
                        words_q <= '{first: hdr_w0, second: hdr_w1};
                    end
                end
                ST_DELAY: begin
                    if (cnt == D_LAST) begin
                        st  <= ST_LEAD;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_LEAD: begin
                    if (cnt == L_LAST) begin
                        st  <= ST_CELLS;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_CELLS: begin
                    if (cell_end && last_cell) begin
                        st <= done_st;
                    end
                end
                ST_HOLD: begin
                    if (sect_mark) begin
                        st  <= ST_TAIL;
                        cnt <= '0;
                    end
                end
                ST_TAIL: begin
                    if (cnt == T_LAST) begin
                        st <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_done <= 1'b0;
        end else begin
            word_done <= word_end;
        end
    end

    assign wgate = (st == ST_LEAD) || (st == ST_CELLS) || (st == ST_HOLD) || (st == ST_TAIL);
    assign egate = wgate;
    assign flux  = clk_slot || (data_slot && cur_bit);

endmodule

// File: rtl/hrw_checker.sv
module hrw_checker (
    input logic clk,
    input logic rst,
    input logic wgate,
    input logic egate,
    input logic flux,
    input logic word_done
);
    // R1: outputs quiet on the cycle after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!wgate && !flux && !word_done));

    // R4: no pulse is ever written without the write gate
    assert_flux_gated_R4: assert property (@(posedge clk) disable iff (rst)
        flux |-> wgate);

    // R5: every pulse is a single cycle wide
    assert_pulse_width_R5: assert property (@(posedge clk) disable iff (rst)
        flux |=> !flux);

    // R9: word strobe is one cycle and lands on a cell clock pulse
    assert_word_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        word_done |=> !word_done);
    assert_word_done_on_clock_R9: assert property (@(posedge clk) disable iff (rst)
        word_done |-> flux);

    // R10: both gates move together
    assert_gates_paired_R10: assert property (@(posedge clk) disable iff (rst)
        wgate == egate);

endmodule

bind hdr_rec_writer hrw_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .wgate    (wgate),
    .egate    (egate),
    .flux     (flux),
    .word_done(word_done)
);

// File: tb/hdr_rec_writer_bench.sv
module hdr_rec_writer_bench;

    localparam int NW  = 38;
    localparam int TOT = NW * 16 + 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mark_a = 1'b0, mark_b = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] hw0 = '0, hw1 = '0;
    logic        wg_a, eg_a, fx_a, wd_a;
    logic        wg_b, eg_b, fx_b, wd_b;
    logic        sel = 1'b0;
    logic        wg, eg, fx, wd;
    int          tests = 0;
    int          fails = 0;

    always #5 clk = ~clk;

    hdr_rec_writer #(
        .CELL_CLKS(4), .START_DLY(5), .LEAD_CLKS(3), .TAIL_CLKS(7),
        .PRE_WORDS(34), .POST_CELLS(4)
    ) u_hdr_rec_writer (
        .clk(clk), .rst(rst), .sect_mark(mark_a), .wr_en(wr_en),
        .hdr_w0(hw0), .hdr_w1(hw1),
        .wgate(wg_a), .egate(eg_a), .flux(fx_a), .word_done(wd_a)
    );

    hdr_rec_writer #(
        .CELL_CLKS(6), .START_DLY(0), .LEAD_CLKS(2), .TAIL_CLKS(0),
        .PRE_WORDS(34), .POST_CELLS(4)
    ) u_hdr_rec_writer_b (
        .clk(clk), .rst(rst), .sect_mark(mark_b), .wr_en(wr_en),
        .hdr_w0(hw0), .hdr_w1(hw1),
        .wgate(wg_b), .egate(eg_b), .flux(fx_b), .word_done(wd_b)
    );

    always_comb begin
        wg = sel ? wg_b : wg_a;
        eg = sel ? eg_b : eg_a;
        fx = sel ? fx_b : fx_a;
        wd = sel ? wd_b : wd_a;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic set_mark(input logic v);
        if (sel) mark_b = v;
        else     mark_a = v;
    endtask

    function automatic bit exp_bit(input int k, input logic [15:0] w0, input logic [15:0] w1);
        int          j;
        int          b;
        logic [15:0] w;
        j = k / 16;
        b = k % 16;
        if (j < 34)       w = 16'h0000;
        else if (j == 34) w = 16'h0001;
        else if (j == 35) w = w0;
        else if (j == 36) w = w1;
        else if (j == 37) w = 16'h0151 ^ w0 ^ w1;
        else              w = 16'h0000;
        return w[15 - b];
    endfunction

    task automatic t_reset();
        check(!wg_a && !eg_a && !fx_a && !wd_a, "R1 inst A idle in reset",
              {wg_a, eg_a, fx_a, wd_a}, 0);
        check(!wg_b && !eg_b && !fx_b && !wd_b, "R1 inst B idle in reset",
              {wg_b, eg_b, fx_b, wd_b}, 0);
    endtask

    task automatic t_no_write();
        int hits;
        hits = 0;
        sel = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
        set_mark(1'b1);
        @(negedge clk);
        set_mark(1'b0);
        for (int i = 0; i < 40; i++) begin
            if (wg || eg || fx) hits++;
            @(negedge clk);
        end
        check(hits == 0, "R2 mark without write command", hits, 0);
    endtask

    task automatic t_record(input bit s, input logic [15:0] w0, input logic [15:0] w1,
                            input int D, input int L, input int C, input int T,
                            input bit alter, input bit poke);
        int          S, endn, k, p;
        int          g_first, f_first, e_g, e_f, e_w, post, pre_or, late;
        bit          exp_g, exp_f, exp_w;
        logic [15:0] dec [NW];
        for (int i = 0; i < NW; i++) dec[i] = '0;
        S = D + L + 1;
        endn = D + L + TOT * C + 1;
        g_first = -1; f_first = -1;
        e_g = 0; e_f = 0; e_w = 0; post = 0; pre_or = 0; late = 0;
        sel = s;
        @(negedge clk);
        hw0 = w0; hw1 = w1; wr_en = 1'b1;
        set_mark(1'b1);
        @(negedge clk);
        set_mark(1'b0);
        if (alter) begin
            hw0 = ~w0; hw1 = ~w1;   // R12 stimulus
        end
        for (int n = 1; n <= endn; n++) begin
            exp_g = (n >= D + 1) && ((n < endn) || (T > 0));
            if (wg !== exp_g || eg !== exp_g) e_g++;
            if (wg === 1'b1 && g_first < 0) g_first = n;
            if (fx === 1'b1 && f_first < 0) f_first = n;
            exp_f = 1'b0;
            exp_w = 1'b0;
            if (n >= S && n < S + TOT * C) begin
                k = (n - S) / C;
                p = (n - S) % C;
                exp_f = (p == 0) || ((p == C / 2) && exp_bit(k, w0, w1));
                if (p == C / 2 && k < NW * 16) dec[k / 16][15 - (k % 16)] = (fx === 1'b1);
                if (k >= NW * 16 && fx === 1'b1) post++;
            end
            if (n > S && ((n - S) % (16 * C)) == 0 && ((n - S) / (16 * C)) <= NW) exp_w = 1'b1;
            if (fx !== exp_f) e_f++;
            if (wd !== exp_w) e_w++;
            // R11 stimulus: stray mark in mid-record
            if (poke && n == S + 100) set_mark(1'b1);
            else if (poke && n == S + 101) set_mark(1'b0);
            if (n < endn) @(negedge clk);
        end
        for (int i = 0; i < 34; i++) pre_or = pre_or | int'(dec[i]);
        check(g_first == D + 1, "R3 gate rise after start delay", g_first, D + 1);
        check(f_first == D + L + 1, "R4 first pulse after guard", f_first, D + L + 1);
        check(e_f == 0, poke ? "R11 R5 cell pulse pattern with stray mark" : "R5 cell pulse pattern", e_f, 0);
        check(e_w == 0, "R9 word strobe placement", e_w, 0);
        check(e_g == 0, "R10 gates during record", e_g, 0);
        check(pre_or == 0, "R6 preamble all zero", pre_or, 0);
        check(dec[34] == 16'h0001, "R6 sync word", dec[34], 16'h0001);
        check(dec[35] == w0, alter ? "R12 R6 first header word" : "R6 first header word", dec[35], w0);
        check(dec[36] == w1, alter ? "R12 R6 second header word" : "R6 second header word", dec[36], w1);
        check(dec[37] == (16'h0151 ^ w0 ^ w1), "R7 checksum word", dec[37], 16'h0151 ^ w0 ^ w1);
        check(post == 4, "R8 postamble clock pulses", post, 4);
        wr_en = 1'b0;
        e_g = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (fx !== 1'b0) late++;
            if (wg !== (T > 0) || eg !== (T > 0)) e_g++;
        end
        check(late == 0, "R8 no pulses after postamble", late, 0);
        check(e_g == 0, "R10 gates after record", e_g, 0);
        if (T > 0) begin
            e_g = 0;
            @(negedge clk);
            set_mark(1'b1);
            @(negedge clk);
            set_mark(1'b0);
            for (int m = 1; m <= T + 1; m++) begin
                exp_g = (m <= T);
                if (wg !== exp_g || eg !== exp_g) e_g++;
                if (m <= T) @(negedge clk);
            end
            check(e_g == 0, "R10 tail after next mark", e_g, 0);
        end
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_no_write();
        t_record(1'b0, 16'h1234, 16'hABCD, 5, 3, 4, 7, 1'b1, 1'b1);
        t_record(1'b0, 16'hFFFF, 16'h0000, 5, 3, 4, 7, 1'b0, 1'b0);
        t_record(1'b1, 16'h0150, 16'h0001, 0, 2, 6, 0, 1'b0, 1'b1);
        t_record(1'b1, 16'h8001, 16'h7FFE, 0, 2, 6, 0, 1'b1, 1'b0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired act=%0d exp=%0d", 200000, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule